// File: doc/BRIEF.md
# Maskable Interrupt Acknowledge Sequencer

This block decides when a level-sensitive maskable interrupt request is taken and then runs the acknowledge handshake on a simple four-state bus-cycle model. The request line is registered on every rising clock edge. A request is accepted only at an instruction boundary, which the execution side marks with a one-clock strobe, and only while the interrupt-enable bit of the incoming flags word is set.

On acceptance the block pulses a clear for the enable bit and keeps a copy of the flags word as it stood before the response, so that the execution side can save it. It then runs two acknowledge bus cycles back to back. A lock output is held low across the joint between them, and a local hold request is not granted until the sequence has finished. The type byte that the external interrupt controller drives in the second cycle is captured and scaled by four into a vector-table address, and a one-clock done pulse marks it as valid.

A request that is still high is taken again at any later boundary where the enable bit is set once more.

Top module: `intack_seq`

## Requirements
- R1: The request input is registered on each rising clock edge, and acceptance uses the registered value. A request that first goes high in the same clock period as the boundary strobe is not taken at that boundary.
- R2: A request is accepted only on a clock edge where the boundary strobe is high, the registered request is high and the enable bit (bit 9 of the flags input) is 1. Without the strobe, or with the enable bit at 0, nothing starts and `ie_clr_o` stays 0.
- R3: In the clock after acceptance, `ie_clr_o` is high for exactly one clock. `flags_save_o` holds the flags input as sampled at the acceptance edge, with bit 9 still 1.
- R4: The response consists of two acknowledge cycles with no gap between them. Each cycle has four states, T1 to T4, and `ack_o` is high in T2 and T3 of each cycle. The first T1 is the clock right after acceptance.
- R5: `lock_n_o` is 0 from T2 of the first acknowledge cycle through T2 of the second, and 1 at every other time.
- R6: `hold_gnt_o` follows `hold_req_i` while no sequence is running and no acceptance is taking place. It is 0 from acceptance through T4 of the second cycle.
- R7: `vec_type_o` takes `data_i` at the rising edge that ends T3 of the second cycle. `vec_addr_o` equals that byte times four (byte in bits 9:2, zeros in bits 1:0).
- R8: `done_o` is high for exactly one clock, in T4 of the second cycle.
- R9: A boundary strobe that arrives while a sequence is running is ignored. A request held high is accepted again at the first boundary after the sequence ends where the enable bit is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_i | input | 1 | Level-sensitive maskable request |
| boundary_i | input | 1 | Instruction or block-element end strobe |
| flags_i | input | 16 | Current flags word; bit 9 is the interrupt enable |
| hold_req_i | input | 1 | Local bus hold request |
| data_i | input | 8 | Data bus carrying the type byte |
| ack_o | output | 1 | Acknowledge strobe (T2 and T3) |
| lock_n_o | output | 1 | Active-low bus lock |
| hold_gnt_o | output | 1 | Hold grant |
| ie_clr_o | output | 1 | One-clock pulse that clears the enable bit |
| flags_save_o | output | 16 | Flags word from before the response |
| vec_type_o | output | 8 | Captured interrupt type |
| vec_addr_o | output | 10 | Vector-table address, type times four |
| done_o | output | 1 | Vector address valid, one clock |

## Verification
The bench raises the request in the same period as the boundary strobe. A design that tests the raw line instead of its registered copy would start a sequence there. It drives the correct type byte only during T3 of the second cycle, so a design that latches one clock early or late returns the complement. It checks the lock level in every state of both cycles, where an off-by-one edge shows up as a wrong level at the joint. It also holds the hold request high for the whole sequence and strobes a boundary with the enable bit set while busy, which catches an early grant or a restarted sequence.

// File: rtl/intack_pkg.sv
package intack_pkg;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_T1,
        PH_T2,
        PH_T3,
        PH_T4
    } phase_e;

    typedef struct packed {
        phase_e ph;
        logic   first;
        logic   last;
    } buspos_t;

    // scale a type value into a table pointer (four bytes per entry)
    function automatic logic [17:0] scale_by4(input logic [15:0] t);
        return {t, 2'b00};
    endfunction

endpackage

// File: rtl/intack_sampler.sv
module intack_sampler (
    input  logic clk,
    input  logic rst,
    input  logic irq,
    input  logic boundary,
    input  logic ie,
    input  logic busy,
    output logic accept
);
    logic irq_q;

    always_ff @(posedge clk) begin
        if (rst) irq_q <= 1'b0;
        else     irq_q <= irq;
    end

    assign accept = boundary && irq_q && ie && !busy;

    // R1: acceptance needs the request to have been seen at the previous edge
    a_r1_registered_req: assert property (@(posedge clk) disable iff (rst)
        accept |-> $past(irq));

endmodule

// File: rtl/intack_buscyc.sv
module intack_buscyc
    import intack_pkg::*;
#(
    parameter int NUM_ACK = 2
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    start,
    output buspos_t pos,
    output logic    ack,
    output logic    lock_n,
    output logic    busy
);
    localparam int CW = (NUM_ACK > 1) ? $clog2(NUM_ACK) : 1;

    phase_e        phase;
    logic [CW-1:0] cyc;
    logic          last_cyc;
    logic          first_cyc;

    assign last_cyc  = (cyc == CW'(NUM_ACK - 1));
    assign first_cyc = (cyc == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            phase <= PH_IDLE;
            cyc   <= '0;
        end else begin
            unique case (phase)
                PH_IDLE: if (start) begin
                    phase <= PH_T1;
                    cyc   <= '0;
                end
                PH_T1: phase <= PH_T2;
                PH_T2: phase <= PH_T3;
                PH_T3: phase <= PH_T4;
                PH_T4: if (last_cyc) begin
                    phase <= PH_IDLE;
                end else begin
                    phase <= PH_T1;
                    cyc   <= cyc + 1'b1;
                end
                default: phase <= PH_IDLE;
            endcase
        end
    end

    assign busy      = (phase != PH_IDLE);
    assign pos.ph    = phase;
    assign pos.first = first_cyc;
    assign pos.last  = last_cyc;
    assign ack       = (phase == PH_T2) || (phase == PH_T3);

    // lock spans T2 of the first cycle through T2 of the last one
    always_comb begin
        lock_n = 1'b1;
        if (busy) begin
            lock_n = 1'b0;
            if (first_cyc && phase == PH_T1)                     lock_n = 1'b1;
            if (last_cyc && (phase == PH_T3 || phase == PH_T4)) lock_n = 1'b1;
        end
    end

    // R4: no idle state between cycles; a non-final T4 leads straight to T1
    a_r4_back_to_back: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_T4 && !last_cyc) |=> (phase == PH_T1 && ack == 1'b0));

    // R4: a start from idle always enters T1
    a_r4_start_t1: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_IDLE && start) |=> (phase == PH_T1 && first_cyc));

endmodule

// File: rtl/intack_seq.sv
module intack_seq
    import intack_pkg::*;
#(
    parameter int FLAGS_W = 16,
    parameter int IE_BIT  = 9,
    parameter int TYPE_W  = 8,
    parameter int NUM_ACK = 2
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               irq_i,
    input  logic               boundary_i,
    input  logic [FLAGS_W-1:0] flags_i,
    input  logic               hold_req_i,
    input  logic [TYPE_W-1:0]  data_i,
    output logic               ack_o,
    output logic               lock_n_o,
    output logic               hold_gnt_o,
    output logic               ie_clr_o,
    output logic [FLAGS_W-1:0] flags_save_o,
    output logic [TYPE_W-1:0]  vec_type_o,
    output logic [TYPE_W+1:0]  vec_addr_o,
    output logic               done_o
);
    localparam int ADDR_W = TYPE_W + 2;

    logic    accept;
    logic    busy;
    buspos_t pos;
    logic    latch_type;

    intack_sampler u_sampler (
        .clk      (clk),
        .rst      (rst),
        .irq      (irq_i),
        .boundary (boundary_i),
        .ie       (flags_i[IE_BIT]),
        .busy     (busy),
        .accept   (accept)
    );

    intack_buscyc #(.NUM_ACK(NUM_ACK)) u_bus (
        .clk    (clk),
        .rst    (rst),
        .start  (accept),
        .pos    (pos),
        .ack    (ack_o),
        .lock_n (lock_n_o),
        .busy   (busy)
    );

    assign latch_type = (pos.ph == PH_T3) && pos.last;
    assign done_o     = (pos.ph == PH_T4) && pos.last;
    assign hold_gnt_o = hold_req_i && !busy && !accept;

    always_ff @(posedge clk) begin
        if (rst) begin
            ie_clr_o     <= 1'b0;
            flags_save_o <= '0;
            vec_type_o   <= '0;
            vec_addr_o   <= '0;
        end else begin
            ie_clr_o <= accept;
            if (accept) flags_save_o <= flags_i;
            if (latch_type) begin
                vec_type_o <= data_i;
                vec_addr_o <= ADDR_W'(scale_by4(16'(data_i)));
            end
        end
    end

    // R5: lock falls at the start of the first acknowledge strobe
    a_r5_lock_fall: assert property (@(posedge clk) disable iff (rst)
        $fell(lock_n_o) |-> ack_o);

    // R5: lock releases while the last acknowledge strobe is still high
    a_r5_lock_rise: assert property (@(posedge clk) disable iff (rst)
        $rose(lock_n_o) |-> ack_o);

    // R6: no grant while the sequence owns the bus
    a_r6_no_hold_busy: assert property (@(posedge clk) disable iff (rst)
        hold_gnt_o |-> (lock_n_o && !ack_o && !done_o));

    // R3: the enable clear is a single pulse
    a_r3_clr_pulse: assert property (@(posedge clk) disable iff (rst)
        ie_clr_o |=> !ie_clr_o);

    // R8: done is a single pulse
    a_r8_done_pulse: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o);

    // R7: the address matches the captured type when done
    a_r7_addr_match: assert property (@(posedge clk) disable iff (rst)
        done_o |-> (vec_addr_o == ADDR_W'({vec_type_o, 2'b00})));

endmodule

// File: tb/tb_intack_seq.sv
`timescale 1ns/100ps
module tb_intack_seq;
    localparam logic [15:0] IE = 16'h0200;

    logic        clk = 1'b0;
    logic        rst;
    logic        irq_i, boundary_i, hold_req_i;
    logic [15:0] flags_i;
    logic [7:0]  data_i;
    logic        ack_o, lock_n_o, hold_gnt_o, ie_clr_o, done_o;
    logic [15:0] flags_save_o;
    logic [7:0]  vec_type_o;
    logic [9:0]  vec_addr_o;

    int nvec = 0;
    int nerr = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    intack_seq dut (
        .clk(clk), .rst(rst), .irq_i(irq_i), .boundary_i(boundary_i),
        .flags_i(flags_i), .hold_req_i(hold_req_i), .data_i(data_i),
        .ack_o(ack_o), .lock_n_o(lock_n_o), .hold_gnt_o(hold_gnt_o),
        .ie_clr_o(ie_clr_o), .flags_save_o(flags_save_o),
        .vec_type_o(vec_type_o), .vec_addr_o(vec_addr_o), .done_o(done_o)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        nvec++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp, $time);
        end
    endtask

    task automatic quiet(input string tag, input int n);
        for (int i = 0; i < n; i++) begin
            chk({tag, " ie_clr"}, 32'(ie_clr_o), 0);
            chk({tag, " ack"},    32'(ack_o), 0);
            chk({tag, " lock_n"}, 32'(lock_n_o), 1);
            @(negedge clk);
        end
    endtask

    // leaves the bench at the negedge inside T1 of the first cycle
    task automatic do_accept(input logic [15:0] fl, input bit raise);
        flags_i = fl | IE;
        if (raise) begin
            irq_i = 1'b1;
            @(negedge clk);
        end
        boundary_i = 1'b1;
        @(negedge clk);
        boundary_i = 1'b0;
        chk("R3 flags_save", 32'(flags_save_o), 32'(fl | IE));
        flags_i = fl & ~IE;
    endtask

    task automatic seq_run(input logic [7:0] ty, input bit hold, input bit intrude);
        hold_req_i = hold;
        for (int k = 0; k <= 8; k++) begin
            chk("R5 lock_n", 32'(lock_n_o), 32'(!(k >= 1 && k <= 5)));
            chk("R4 ack",    32'(ack_o),    32'(k == 1 || k == 2 || k == 5 || k == 6));
            chk("R8 done",   32'(done_o),   32'(k == 7));
            chk("R6 hold_gnt", 32'(hold_gnt_o), 32'(hold && k == 8));
            if (k == 0) chk("R3 ie_clr", 32'(ie_clr_o), 1);
            else        chk("R9 ie_clr", 32'(ie_clr_o), 0);
            if (k == 7) begin
                chk("R7 vec_type", 32'(vec_type_o), 32'(ty));
                chk("R7 vec_addr", 32'(vec_addr_o), 32'(ty) * 4);
            end
            data_i = (k == 6) ? ty : ~ty;
            if (intrude && k == 3) begin
                boundary_i = 1'b1;
                flags_i    = flags_i | IE;
            end
            if (intrude && k == 4) begin
                boundary_i = 1'b0;
                flags_i    = flags_i & ~IE;
            end
            @(negedge clk);
        end
        hold_req_i = 1'b0;
    endtask

    task automatic t_reset;
        chk("R2 reset ack", 32'(ack_o), 0);
        chk("R5 reset lock_n", 32'(lock_n_o), 1);
        chk("R8 reset done", 32'(done_o), 0);
        chk("R3 reset ie_clr", 32'(ie_clr_o), 0);
        chk("R7 reset vec_addr", 32'(vec_addr_o), 0);
        chk("R6 reset hold_gnt", 32'(hold_gnt_o), 0);
    endtask

    task automatic t_no_boundary;
        irq_i = 1'b1; flags_i = IE;
        @(negedge clk);
        quiet("R2 no boundary", 3);
        irq_i = 1'b0;
        @(negedge clk);
    endtask

    task automatic t_masked;
        irq_i = 1'b1; flags_i = 16'h0000;
        @(negedge clk);
        boundary_i = 1'b1;
        @(negedge clk);
        boundary_i = 1'b0;
        quiet("R2 masked", 3);
        irq_i = 1'b0;
        @(negedge clk);
    endtask

    task automatic t_same_cycle;
        flags_i = IE; irq_i = 1'b1; boundary_i = 1'b1;
        @(negedge clk);
        boundary_i = 1'b0;
        quiet("R1 same period", 3);
        irq_i = 1'b0;
        @(negedge clk);
        @(negedge clk);
    endtask

    task automatic t_hold_idle;
        hold_req_i = 1'b1;
        #1;
        chk("R6 idle grant", 32'(hold_gnt_o), 1);
        @(negedge clk);
        hold_req_i = 1'b0;
        #1;
        chk("R6 idle release", 32'(hold_gnt_o), 0);
    endtask

    task automatic t_basic(input logic [7:0] ty, input logic [15:0] fl, input bit hold);
        do_accept(fl, 1'b1);
        seq_run(ty, hold, 1'b0);
        irq_i = 1'b0;
        @(negedge clk);
    endtask

    task automatic t_intrude;
        do_accept(16'h0055, 1'b1);
        seq_run(8'h3C, 1'b0, 1'b1);
        quiet("R9 after busy boundary", 2);
        irq_i = 1'b0;
        @(negedge clk);
    endtask

    task automatic t_reservice;
        do_accept(16'h0001, 1'b1);
        seq_run(8'h21, 1'b0, 1'b0);
        // request still high: enable restored at a new boundary
        do_accept(16'h0002, 1'b0);
        seq_run(8'hA2, 1'b0, 1'b0);
        irq_i = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            nerr++;
            $display("FAIL watchdog expired");
            $display("  == %0d vectors applied, %0d miscompares ==", nvec, nerr);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; irq_i = 1'b0; boundary_i = 1'b0; hold_req_i = 1'b0;
        flags_i = '0; data_i = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_no_boundary();
        t_masked();
        t_same_cycle();
        t_hold_idle();
        t_basic(8'h08, 16'h0100, 1'b0);
        t_basic(8'hFF, 16'hF0F0, 1'b1);
        t_basic(8'h00, 16'h0000, 1'b1);
        t_intrude();
        t_reservice();
        finished = 1;
        $display("  == %0d vectors applied, %0d miscompares ==", nvec, nerr);
        $finish;
    end
endmodule